// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table held in memory. A requester hands it one translation at a time, with a flag that says whether the access is a write. The walker takes the base of the top-level table from a root input. It samples that input when it accepts the request, so software can change the root between walks, for example on a context switch. It then fetches a directory entry and a leaf entry, one after the other, through a simple memory port.

Each entry carries a frame number in bits [31:12]. Its control bits are: present in bit 0, writable in bit 1, used in bit 5 and modified in bit 6. A walk ends in one of three ways:
- a physical address, built from the leaf frame and the untouched page offset;
- a page fault;
- a protection fault.

On a successful access the walker stores the leaf entry back with the used bit set, and with the modified bit also set for a write. It skips that store when the bits are already set.

Top module: `pgwalk_top`

## Requirements
- R1: The virtual address splits into bits [31:22] (directory index), bits [21:12] (leaf index) and bits [11:0] (offset). The directory entry is read from root + directory index × 4, as the first memory access after a request is accepted.
- R2: The leaf entry is read from (directory frame << 12) + leaf index × 4.
- R3: The root base is sampled when the request is accepted. Changing it afterwards does not affect the walk in progress. A different root yields that root's mapping.
- R4: If the present bit (bit 0) is clear in either entry, the response carries fault code 1 (page fault) and physical address 0, and no memory write is made.
- R5: A write is refused with fault code 2 (protection fault), physical address 0 and no memory write when the writable bit (bit 1) is clear in the directory entry or in the leaf entry. A read through such entries succeeds.
- R6: On success, fault code is 0 and the physical address is the leaf frame (bits [31:12]) joined with the unchanged 12-bit offset.
- R7: On success the leaf entry is written back with used (bit 5) set, and modified (bit 6) also set for a write. All other bits are kept.
- R8: The write-back is skipped when the bits it would set are already set.
- R9: Only one walk is in flight. req_ready is high only when idle, and stays low from acceptance until the response is taken.
- R10: A response held off by rsp_ready low keeps its valid, address and fault stable. A memory request held off by mem_ready low keeps its valid, direction and address stable.
- R11: After reset the walker is idle: req_ready high, rsp_valid low, mem_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_base | input | 32 | Byte address of the top-level table |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = entry write-back, 0 = entry read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value for a write-back |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Reads and writes go through the same mapping twice in a row. A fresh entry must be written back once and a second identical access must not, which separates correct write-back from always-write and never-write variants. Missing entries are placed at each level, and read-only flags are set on the leaf alone and on the directory alone, with both access kinds. This shows that each level is checked and that the page fault takes precedence. The largest indices with both extreme offsets, and a second root holding a different mapping for the same address, expose errors in index slicing, address arithmetic and root sampling. Memory stalls, read latencies of zero to two cycles and response backpressure vary around these cases to test that held requests stay stable.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    parameter int VA_W      = 32;
    parameter int PA_W      = 32;
    parameter int PTE_W     = 32;
    parameter int IDX_W     = 10;
    parameter int OFF_W     = 12;
    parameter int ENT_SHIFT = 2;
    parameter int FRAME_W   = PTE_W - OFF_W;

    // control bit positions inside an entry
    parameter int BIT_PRESENT  = 0;
    parameter int BIT_WRITABLE = 1;
    parameter int BIT_USED     = 5;
    parameter int BIT_DIRTY    = 6;

    // virtual address field positions
    parameter int LEAF_LSB = OFF_W;
    parameter int DIR_LSB  = OFF_W + IDX_W;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_WT,
        ST_LEAF_RD,
        ST_LEAF_WT,
        ST_WBACK,
        ST_RESP
    } walk_st_e;

    typedef struct packed {
        walk_st_e            st;
        logic [VA_W-1:0]     vaddr;
        logic                write;
        logic [PA_W-1:0]     root;
        logic [FRAME_W-1:0]  dir_frame;
        logic [PTE_W-1:0]    leaf_new;
        logic [PA_W-1:0]     paddr;
        fault_e              fault;
    } walk_regs_t;

endpackage

// File: rtl/pgwalk_entry_addr.sv
module pgwalk_entry_addr
    import pgwalk_pkg::*;
(
    input  logic [PA_W-1:0]    root,
    input  logic [FRAME_W-1:0] dir_frame,
    input  logic [IDX_W-1:0]   dir_idx,
    input  logic [IDX_W-1:0]   leaf_idx,
    output logic [PA_W-1:0]    dir_addr,
    output logic [PA_W-1:0]    leaf_addr
);

    localparam int PAD_W = PA_W - IDX_W - ENT_SHIFT;

    logic [PA_W-1:0] dir_ofs;
    logic [PA_W-1:0] leaf_ofs;
    logic [PA_W-1:0] leaf_base;

    always_comb begin
        dir_ofs   = {{PAD_W{1'b0}}, dir_idx,  {ENT_SHIFT{1'b0}}};
        leaf_ofs  = {{PAD_W{1'b0}}, leaf_idx, {ENT_SHIFT{1'b0}}};
        leaf_base = {dir_frame, {OFF_W{1'b0}}};
        dir_addr  = root + dir_ofs;
        leaf_addr = leaf_base + leaf_ofs;
    end

endmodule

// File: rtl/pgwalk_pte_eval.sv
module pgwalk_pte_eval
    import pgwalk_pkg::*;
(
    input  logic [PTE_W-1:0]   pte,
    input  logic               write,
    output logic               present,
    output logic               writable,
    output logic [FRAME_W-1:0] frame,
    output logic [PTE_W-1:0]   upd_pte,
    output logic               changed
);

    logic [PTE_W-1:0] set_mask;

    always_comb begin
        set_mask            = '0;
        set_mask[BIT_USED]  = 1'b1;
        set_mask[BIT_DIRTY] = write;
        present             = pte[BIT_PRESENT];
        writable            = pte[BIT_WRITABLE];
        frame               = pte[PTE_W-1:OFF_W];
        upd_pte             = pte | set_mask;
        changed             = (upd_pte != pte);
    end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  root_base,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_write,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);

    walk_regs_t q, d;

    logic [PA_W-1:0]    dir_addr;
    logic [PA_W-1:0]    leaf_addr;
    logic               ent_present;
    logic               ent_writable;
    logic [FRAME_W-1:0] ent_frame;
    logic [PTE_W-1:0]   ent_upd;
    logic               ent_changed;

    pgwalk_entry_addr u_addr (
        .root      (q.root),
        .dir_frame (q.dir_frame),
        .dir_idx   (q.vaddr[DIR_LSB +: IDX_W]),
        .leaf_idx  (q.vaddr[LEAF_LSB +: IDX_W]),
        .dir_addr  (dir_addr),
        .leaf_addr (leaf_addr)
    );

    pgwalk_pte_eval u_eval (
        .pte      (mem_rdata),
        .write    (q.write),
        .present  (ent_present),
        .writable (ent_writable),
        .frame    (ent_frame),
        .upd_pte  (ent_upd),
        .changed  (ent_changed)
    );

    // next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st        = ST_DIR_RD;
                    d.vaddr     = req_vaddr;
                    d.write     = req_write;
                    d.root      = root_base;
                    d.dir_frame = '0;
                    d.leaf_new  = '0;
                    d.paddr     = '0;
                    d.fault     = FLT_NONE;
                end
            end
            ST_DIR_RD: begin
                if (mem_ready) d.st = ST_DIR_WT;
            end
            ST_DIR_WT: begin
                if (mem_rvalid) begin
                    if (!ent_present) begin
                        d.fault = FLT_PAGE;
                        d.st    = ST_RESP;
                    end else if (q.write && !ent_writable) begin
                        d.fault = FLT_PROT;
                        d.st    = ST_RESP;
                    end else begin
                        d.dir_frame = ent_frame;
                        d.st        = ST_LEAF_RD;
                    end
                end
            end
            ST_LEAF_RD: begin
                if (mem_ready) d.st = ST_LEAF_WT;
            end
            ST_LEAF_WT: begin
                if (mem_rvalid) begin
                    if (!ent_present) begin
                        d.fault = FLT_PAGE;
                        d.st    = ST_RESP;
                    end else if (q.write && !ent_writable) begin
                        d.fault = FLT_PROT;
                        d.st    = ST_RESP;
                    end else begin
                        d.paddr = {ent_frame, q.vaddr[OFF_W-1:0]};
                        if (ent_changed) begin
                            d.leaf_new = ent_upd;
                            d.st       = ST_WBACK;
                        end else begin
                            d.st = ST_RESP;
                        end
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ready) d.st = ST_RESP;
            end
            ST_RESP: begin
                if (rsp_ready) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.vaddr     <= '0;
            q.write     <= 1'b0;
            q.root      <= '0;
            q.dir_frame <= '0;
            q.leaf_new  <= '0;
            q.paddr     <= '0;
            q.fault     <= FLT_NONE;
        end else begin
            q <= d;
        end
    end

    // outputs
    always_comb begin
        req_ready = (q.st == ST_IDLE);
        rsp_valid = (q.st == ST_RESP);
        rsp_paddr = q.paddr;
        rsp_fault = q.fault;
        mem_valid = (q.st == ST_DIR_RD) || (q.st == ST_LEAF_RD) || (q.st == ST_WBACK);
        mem_write = (q.st == ST_WBACK);
        mem_wdata = q.leaf_new;
        unique case (q.st)
            ST_DIR_RD:            mem_addr = dir_addr;
            ST_LEAF_RD, ST_WBACK: mem_addr = leaf_addr;
            default:              mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/pgwalk_sva.sv
module pgwalk_sva
    import pgwalk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [PA_W-1:0]  root_base,
    input logic             req_valid,
    input logic             req_ready,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_write,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic [1:0]       rsp_fault,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic             mem_write,
    input logic [PA_W-1:0]  mem_addr,
    input logic [PTE_W-1:0] mem_wdata
);

    logic             acc_q;
    logic [PA_W-1:0]  root_q;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= 1'b0;
            root_q <= '0;
            va_q   <= '0;
            wr_q   <= 1'b0;
        end else begin
            acc_q <= req_valid && req_ready;
            if (req_valid && req_ready) begin
                root_q <= root_base;
                va_q   <= req_vaddr;
                wr_q   <= req_write;
            end
        end
    end

    AST_DIR_FETCH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q |-> (mem_valid && !mem_write &&
                   mem_addr == root_q + {{(PA_W-IDX_W-ENT_SHIFT){1'b0}}, va_q[DIR_LSB +: IDX_W], {ENT_SHIFT{1'b0}}})); // R1

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0)); // R4

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault == 2'd0) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0])); // R6

    AST_WBACK_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> (mem_wdata[BIT_USED] && mem_wdata[BIT_PRESENT])); // R7

    AST_WBACK_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write && wr_q) |-> mem_wdata[BIT_DIRTY]); // R7

    AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_valid) |-> !req_ready); // R9

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write))); // R10

endmodule

bind pgwalk_top pgwalk_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .root_base (root_base),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_vaddr (req_vaddr),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] root_base = 32'h0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = 32'h0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_valid;
    logic        mem_ready = 1'b1;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = 32'h0;

    always #2 clk = ~clk;  // 250 MHz

    pgwalk_top dut_i (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    logic [31:0] tbl [0:4095];

    logic [33:0] exp_q [$];
    string       tag_q [$];

    int  lat_sel = 0;
    bit  stall_en = 0;
    int  bp_len = 0;
    int  bp_cnt = 0;
    int  wr_cnt = 0;
    int  cyc = 0;

    bit          hs_seen = 0;
    bit          hs_write = 0;
    logic [31:0] hs_addr = 0;
    logic [31:0] hs_data = 0;
    bit          rd_pend = 0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr = 0;

    function automatic int widx(input logic [31:0] a);
        return int'(a[13:2]);
    endfunction

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // memory model and response monitor (scoreboard side)
    always @(negedge clk) begin
        cyc++;
        mem_rvalid = 1'b0;
        if (hs_seen) begin
            hs_seen = 0;
            if (hs_write) begin
                tbl[widx(hs_addr)] = hs_data;
                wr_cnt++;
            end else begin
                rd_pend = 1;
                rd_cnt  = lat_sel;
                rd_addr = hs_addr;
            end
        end
        if (rd_pend) begin
            if (rd_cnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = tbl[widx(rd_addr)];
                rd_pend    = 0;
            end else begin
                rd_cnt--;
            end
        end
        mem_ready = !(stall_en && (cyc % 3 != 0));
        if (rst_n && mem_valid && mem_ready) begin
            hs_seen  = 1;
            hs_write = mem_write;
            hs_addr  = mem_addr;
            hs_data  = mem_wdata;
        end
        if (rsp_valid) begin
            if (bp_cnt < bp_len) begin
                rsp_ready = 1'b0;
                bp_cnt++;
            end else begin
                rsp_ready = 1'b1;
            end
        end else begin
            rsp_ready = (bp_len == 0);
            bp_cnt    = 0;
        end
        if (rst_n && rsp_valid && rsp_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected response", {30'd0, rsp_fault, rsp_paddr}, 64'd0);
            end else begin
                logic [33:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rsp_fault, rsp_paddr} == e, t, {30'd0, rsp_fault, rsp_paddr}, {30'd0, e});
            end
            bp_cnt = 0;
        end
    end

    // independent prediction from the requirements
    task automatic predict(input logic [31:0] va, input bit wr, input logic [31:0] root,
                           output logic [31:0] pa, output logic [1:0] f, output int nwr,
                           output int lidx, output logic [31:0] leaf_after);
        logic [31:0] e1, e2, a2;
        pa = 0; f = 0; nwr = 0; lidx = -1; leaf_after = 0;
        e1 = tbl[widx(root + {20'd0, va[31:22], 2'b00})];
        if (!e1[0]) f = 2'd1;
        else if (wr && !e1[1]) f = 2'd2;
        else begin
            a2 = {e1[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
            lidx = widx(a2);
            e2 = tbl[lidx];
            leaf_after = e2;
            if (!e2[0]) f = 2'd1;
            else if (wr && !e2[1]) f = 2'd2;
            else begin
                pa = {e2[31:12], va[11:0]};
                leaf_after = e2 | 32'h20 | (wr ? 32'h40 : 32'h0);
                nwr = (leaf_after != e2) ? 1 : 0;
            end
        end
    endtask

    // driver: push the expectation, then issue the request
    task automatic run_walk(input logic [31:0] va, input bit wr, input logic [31:0] root,
                            input string tag, input int lat, input bit stall, input int bp);
        logic [31:0] pa, leaf_after;
        logic [1:0]  f;
        int          nwr, lidx;
        predict(va, wr, root, pa, f, nwr, lidx, leaf_after);
        lat_sel  = lat;
        stall_en = stall;
        bp_len   = bp;
        exp_q.push_back({f, pa});
        tag_q.push_back(tag);
        wr_cnt    = 0;
        req_vaddr = va;
        req_write = wr;
        root_base = root;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R9 busy after accept"}, {63'd0, req_ready}, 64'd0);
        root_base = 32'hDEAD_0000;  // R3: must not disturb the walk in flight
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(wr_cnt == nwr, {tag, " R7/R8 write-back count"}, 64'(wr_cnt), 64'(nwr));
        if (lidx >= 0)
            chk(tbl[lidx] == leaf_after, {tag, " R7 leaf entry"}, {32'd0, tbl[lidx]}, {32'd0, leaf_after});
    endtask

    function automatic logic [31:0] mkva(input int d, input int l, input int o);
        return {d[9:0], l[9:0], o[11:0]};
    endfunction

    initial begin
        for (int i = 0; i < 4096; i++) tbl[i] = 32'h0;
        tbl[1]     = 32'h0000_1003;  // dir -> frame 1, writable
        tbl[2]     = 32'h0000_1001;  // dir -> frame 1, read-only
        tbl[1023]  = 32'h0000_2003;  // dir -> frame 2
        tbl[12'h403] = 32'hABCD_E003;
        tbl[12'h407] = 32'h1234_5001;
        tbl[12'hBFF] = 32'hFEDC_B003;
        tbl[12'h803] = 32'h5555_5003;
        tbl[12'hC01] = 32'h0000_2003; // second root at 0x3000

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R11 reset req_ready", {63'd0, req_ready}, 64'd1);
        chk(rsp_valid == 1'b0, "R11 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
        chk(mem_valid == 1'b0, "R11 reset mem_valid", {63'd0, mem_valid}, 64'd0);

        run_walk(mkva(1, 3, 'h123),      1'b0, 32'h0, "R1 R6 fresh read",            0, 1'b0, 0);
        run_walk(mkva(1, 3, 'h456),      1'b0, 32'h0, "R8 repeat read",              1, 1'b0, 0);
        run_walk(mkva(1, 3, 'h789),      1'b1, 32'h0, "R7 first write stalled",      2, 1'b1, 0);
        run_walk(mkva(1, 3, 'h000),      1'b1, 32'h0, "R8 repeat write",             0, 1'b0, 0);
        run_walk(mkva(5, 3, 'h010),      1'b0, 32'h0, "R4 dir absent",               0, 1'b0, 0);
        run_walk(mkva(5, 3, 'h010),      1'b1, 32'h0, "R4 dir absent write",         1, 1'b0, 0);
        run_walk(mkva(1, 4, 'h020),      1'b1, 32'h0, "R4 leaf absent",              0, 1'b1, 0);
        run_walk(mkva(1, 7, 'h030),      1'b1, 32'h0, "R5 write read-only leaf",     0, 1'b0, 0);
        run_walk(mkva(1, 7, 'h040),      1'b0, 32'h0, "R5 read read-only leaf",      2, 1'b0, 0);
        run_walk(mkva(2, 3, 'h050),      1'b1, 32'h0, "R5 write via read-only dir",  0, 1'b0, 0);
        run_walk(mkva(2, 3, 'h060),      1'b0, 32'h0, "R5 read via read-only dir",   1, 1'b1, 0);
        run_walk(mkva(1023, 1023, 'hFFF), 1'b0, 32'h0, "R2 R6 max indices",          0, 1'b0, 0);
        run_walk(mkva(1023, 1023, 'h000), 1'b1, 32'h0, "R2 R6 max indices write",    1, 1'b0, 0);
        run_walk(mkva(1, 3, 'h123),      1'b0, 32'h3000, "R3 second root",           0, 1'b0, 0);
        run_walk(mkva(1, 3, 'hABC),      1'b1, 32'h3000, "R10 backpressure",         2, 1'b1, 5);
        run_walk(mkva(1, 3, 'h321),      1'b0, 32'h0, "R3 back to first root",       0, 1'b0, 3);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule